// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns level changes on nineteen external request lines into latched interrupt requests and single-cycle event pulses. Each line has its own edge detector. A register decides whether the detector reacts to rising edges, falling edges or both. The first sixteen lines each pick their pin from one of seven sixteen-pin GPIO ports, so 112 pins can reach them. The last three lines are wired straight to dedicated inputs.

The edge detector is an asynchronous capture flop that sits in front of a two-flop synchronizer. Because of it, a pulse narrower than one clock period is still recorded. A detected edge on a line whose interrupt enable is set becomes a sticky pending bit. The combined interrupt output is high while any enabled line is pending. Software clears a pending bit by writing 1 to it. A separate event enable turns each detection into a one-cycle pulse on that line's event output, and the event path never touches the pending register. Software can also raise a request directly through a trigger register.

The register port is a plain word-addressed write strobe with a combinational read mux. Bit i of every per-line register belongs to line i.

Top module: `ext_irq_ctrl`

## Requirements
- R1: With bit i set in the rising-select register (address 2) and in the interrupt-enable register (address 0), a rising edge on line i sets pending bit i (address 5) at the third rising clock edge after the input changes.
- R2: Bit i of the falling-select register (address 3) makes a falling edge on line i a request. With both select bits set, each edge counts. With neither set, no edge on the line has any effect.
- R3: While bit i of the interrupt-enable register is 0, no edge and no software trigger on line i sets pending bit i.
- R4: A pending bit stays set until a write to address 5 carries a 1 in that bit position. Writing 0 leaves it unchanged.
- R5: If a request on line i and a write-1 clear of pending bit i take effect at the same clock edge, the bit ends up set.
- R6: A high pulse shorter than one clock period on a rising-enabled line is recorded as a request.
- R7: For line i below 16, a 4-bit port field at bits 4*(i mod 8) of address 6 (lines 0 to 7) or address 7 (lines 8 to 15) selects the pin. Value p selects gpioPins[16*p + i], and a value of 7 or above makes the line a constant low.
- R8: Lines 16 to 18 take their input from directLines[i-16].
- R9: Writing 1 to bit i of address 4 raises a request on line i at that same clock edge. The register reads back as 0.
- R10: With bit i of the event-enable register (address 1) set, each request on line i drives evtPulse[i] high for exactly one cycle, in the cycle after the edge that would set the pending bit. This happens whatever the interrupt enable holds, and the event path sets no pending bit.
- R11: irqOut is high exactly when some line has both its pending bit and its interrupt-enable bit set.
- R12: After reset every register reads 0, and irqOut and evtPulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 3 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| gpioPins | input | 112 | Seven ports of sixteen pins, port p at bits 16p+15..16p |
| directLines | input | 3 | Inputs of lines 16 to 18 |
| irqOut | output | 1 | Combined interrupt request |
| evtPulse | output | 19 | Per-line one-cycle event pulses |

## Verification
Directed patterns cover each trigger polarity alone and together on separate lines. They also cover a sub-cycle glitch, which shows that the asynchronous capture works and not just clock sampling. Pins are toggled on ports that are not selected, to separate mux routing from plain edge detection. A clear is timed to land on the same edge as a detected request, which exposes the set-versus-clear priority. A seeded random phase then toggles one line at a time under random polarity and enable masks, while the pins of the other ports are also changed, and compares the pending register and irqOut against a bench model.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int PINS_PER_PORT = 16;
  localparam int SEL_FIELD_W   = 4;
  localparam int LINES_PER_SEL = 8;

  localparam logic [2:0] ADDR_INT_EN  = 3'd0;
  localparam logic [2:0] ADDR_EVT_EN  = 3'd1;
  localparam logic [2:0] ADDR_RISE    = 3'd2;
  localparam logic [2:0] ADDR_FALL    = 3'd3;
  localparam logic [2:0] ADDR_SW_TRIG = 3'd4;
  localparam logic [2:0] ADDR_PEND    = 3'd5;
  localparam logic [2:0] ADDR_SEL_LO  = 3'd6;
  localparam logic [2:0] ADDR_SEL_HI  = 3'd7;

  typedef struct packed {
    logic        wrIntEn;
    logic        wrEvtEn;
    logic        wrRise;
    logic        wrFall;
    logic        wrSwTrig;
    logic        wrPendClr;
    logic        wrSelLo;
    logic        wrSelHi;
    logic [31:0] wdata;
  } ctlStrobes_t;

endpackage

// File: rtl/ext_irq_edge_catch.sv
module ext_irq_edge_catch (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic riseEn,
  input  logic fallEn,
  output logic detPulse
);

  logic riseQ;
  logic fallQ;
  logic syncA;
  logic syncB;
  logic syncC;
  logic clrAsync;

  // stage B high acknowledges the capture and releases it asynchronously
  assign clrAsync = !rstN || syncB;

  always_ff @(posedge lineIn or posedge clrAsync) begin
    if (clrAsync) riseQ <= 1'b0;
    else          riseQ <= riseEn;
  end

  always_ff @(negedge lineIn or posedge clrAsync) begin
    if (clrAsync) fallQ <= 1'b0;
    else          fallQ <= fallEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= riseQ | fallQ;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign detPulse = syncB & ~syncC;

endmodule

// File: rtl/ext_irq_ctrl_fsm.sv
module ext_irq_ctrl_fsm
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 19
) (
  input  logic                 regWrite,
  input  logic [2:0]           regAddr,
  input  logic [31:0]          regWdata,
  input  logic [NUM_LINES-1:0] intEn,
  input  logic [NUM_LINES-1:0] evtEn,
  input  logic [NUM_LINES-1:0] riseSel,
  input  logic [NUM_LINES-1:0] fallSel,
  input  logic [NUM_LINES-1:0] pend,
  input  logic [31:0]          selLo,
  input  logic [31:0]          selHi,
  output ctlStrobes_t          strb,
  output logic [31:0]          regRdata
);

  always_comb begin
    strb           = '0;
    strb.wdata     = regWdata;
    strb.wrIntEn   = regWrite && (regAddr == ADDR_INT_EN);
    strb.wrEvtEn   = regWrite && (regAddr == ADDR_EVT_EN);
    strb.wrRise    = regWrite && (regAddr == ADDR_RISE);
    strb.wrFall    = regWrite && (regAddr == ADDR_FALL);
    strb.wrSwTrig  = regWrite && (regAddr == ADDR_SW_TRIG);
    strb.wrPendClr = regWrite && (regAddr == ADDR_PEND);
    strb.wrSelLo   = regWrite && (regAddr == ADDR_SEL_LO);
    strb.wrSelHi   = regWrite && (regAddr == ADDR_SEL_HI);
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_INT_EN: regRdata[NUM_LINES-1:0] = intEn;
      ADDR_EVT_EN: regRdata[NUM_LINES-1:0] = evtEn;
      ADDR_RISE:   regRdata[NUM_LINES-1:0] = riseSel;
      ADDR_FALL:   regRdata[NUM_LINES-1:0] = fallSel;
      ADDR_PEND:   regRdata[NUM_LINES-1:0] = pend;
      ADDR_SEL_LO: regRdata = selLo;
      ADDR_SEL_HI: regRdata = selHi;
      default:     regRdata = '0;
    endcase
  end

endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 19,
  parameter int NUM_PORTS = 7,
  parameter int MUX_LINES = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctlStrobes_t                        strb,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] gpioPins,
  input  logic [NUM_LINES-MUX_LINES-1:0]     directLines,
  output logic [NUM_LINES-1:0]               intEn,
  output logic [NUM_LINES-1:0]               evtEn,
  output logic [NUM_LINES-1:0]               riseSel,
  output logic [NUM_LINES-1:0]               fallSel,
  output logic [NUM_LINES-1:0]               pend,
  output logic [31:0]                        selLo,
  output logic [31:0]                        selHi,
  output logic                               irqOut,
  output logic [NUM_LINES-1:0]               evtPulse
);

  logic [NUM_LINES-1:0] lineVal;
  logic [NUM_LINES-1:0] detVec;
  logic [NUM_LINES-1:0] swVec;
  logic [NUM_LINES-1:0] clrVec;
  logic [NUM_LINES-1:0] trigVec;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn   <= '0;
      evtEn   <= '0;
      riseSel <= '0;
      fallSel <= '0;
      selLo   <= '0;
      selHi   <= '0;
    end else begin
      if (strb.wrIntEn) intEn   <= strb.wdata[NUM_LINES-1:0];
      if (strb.wrEvtEn) evtEn   <= strb.wdata[NUM_LINES-1:0];
      if (strb.wrRise)  riseSel <= strb.wdata[NUM_LINES-1:0];
      if (strb.wrFall)  fallSel <= strb.wdata[NUM_LINES-1:0];
      if (strb.wrSelLo) selLo   <= strb.wdata;
      if (strb.wrSelHi) selHi   <= strb.wdata;
    end
  end

  // source routing: muxed GPIO lines then direct lines
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i < MUX_LINES) begin : g_mux
      localparam int FIELD_LSB = SEL_FIELD_W * (i % LINES_PER_SEL);
      logic [SEL_FIELD_W-1:0] selVal;
      logic [NUM_PORTS-1:0]   cand;
      assign selVal = (i < LINES_PER_SEL) ? selLo[FIELD_LSB +: SEL_FIELD_W]
                                          : selHi[FIELD_LSB +: SEL_FIELD_W];
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign cand[p] = gpioPins[p*PINS_PER_PORT + i];
      end
      always_comb begin
        lineVal[i] = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (selVal == SEL_FIELD_W'(p)) lineVal[i] = cand[p];
        end
      end
    end else begin : g_direct
      assign lineVal[i] = directLines[i-MUX_LINES];
    end

    ext_irq_edge_catch u_catch (
      .clk      (clk),
      .rstN     (rstN),
      .lineIn   (lineVal[i]),
      .riseEn   (riseSel[i]),
      .fallEn   (fallSel[i]),
      .detPulse (detVec[i])
    );
  end

  assign swVec   = strb.wrSwTrig  ? strb.wdata[NUM_LINES-1:0] : '0;
  assign clrVec  = strb.wrPendClr ? strb.wdata[NUM_LINES-1:0] : '0;
  assign trigVec = detVec | swVec;

  // pending: set beats clear; event path registered, no pending side effect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      evtPulse <= '0;
    end else begin
      pend     <= (pend & ~clrVec) | (trigVec & intEn);
      evtPulse <= trigVec & evtEn;
    end
  end

  assign irqOut = |(pend & intEn);

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    ((pend & ~$past(pend) & ~$past(intEn)) == '0)); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (($past(clrVec) & ~$past(trigVec) & pend) == '0)); // R4

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (($past(trigVec & intEn) & ~pend) == '0)); // R5

  AST_SW_TRIG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSwTrig |=> ((pend & $past(strb.wdata[NUM_LINES-1:0] & intEn))
                       == $past(strb.wdata[NUM_LINES-1:0] & intEn))); // R9

  AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & ~$past(evtEn)) == '0)); // R10

  AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pend != '0)); // R11

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 19,
  parameter int NUM_PORTS = 7,
  parameter int MUX_LINES = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               regWrite,
  input  logic [2:0]                         regAddr,
  input  logic [31:0]                        regWdata,
  output logic [31:0]                        regRdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] gpioPins,
  input  logic [NUM_LINES-MUX_LINES-1:0]     directLines,
  output logic                               irqOut,
  output logic [NUM_LINES-1:0]               evtPulse
);

  ctlStrobes_t          strb;
  logic [NUM_LINES-1:0] intEn;
  logic [NUM_LINES-1:0] evtEn;
  logic [NUM_LINES-1:0] riseSel;
  logic [NUM_LINES-1:0] fallSel;
  logic [NUM_LINES-1:0] pend;
  logic [31:0]          selLo;
  logic [31:0]          selHi;

  ext_irq_ctrl_fsm #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .intEn    (intEn),
    .evtEn    (evtEn),
    .riseSel  (riseSel),
    .fallSel  (fallSel),
    .pend     (pend),
    .selLo    (selLo),
    .selHi    (selHi),
    .strb     (strb),
    .regRdata (regRdata)
  );

  ext_irq_datapath #(
    .NUM_LINES (NUM_LINES),
    .NUM_PORTS (NUM_PORTS),
    .MUX_LINES (MUX_LINES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .gpioPins    (gpioPins),
    .directLines (directLines),
    .intEn       (intEn),
    .evtEn       (evtEn),
    .riseSel     (riseSel),
    .fallSel     (fallSel),
    .pend        (pend),
    .selLo       (selLo),
    .selHi       (selHi),
    .irqOut      (irqOut),
    .evtPulse    (evtPulse)
  );

endmodule

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrite = 1'b0;
  logic [2:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic [111:0] gpioPins = '0;
  logic [2:0]   directLines = '0;
  logic         irqOut;
  logic [18:0]  evtPulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .gpioPins(gpioPins),
    .directLines(directLines), .irqOut(irqOut), .evtPulse(evtPulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit hits(input bit r, input bit f, input bit oldV, input bit newV);
    return (r && !oldV && newV) || (f && oldV && !newV);
  endfunction

  task automatic setPort0(input int line, input bit v);
    @(negedge clk);
    if (line < 16) gpioPins[line] = v;
    else           directLines[line-16] = v;
    waitCyc(5);
  endtask

  logic [31:0] rv;
  logic [18:0] model;
  logic [18:0] cfgRise, cfgFall, cfgEn;
  logic [31:0] seedDummy;

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R12 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv);
      check("R12 reset register", rv, 32'h0);
    end
    check("R12 reset irqOut", {31'h0, irqOut}, 32'h0);
    check("R12 reset evtPulse", {13'h0, evtPulse}, 32'h0);

    // R1 rising edge, exact timing
    wr(3'd0, 32'h7FFFF);
    wr(3'd2, 32'h00001);
    @(negedge clk); gpioPins[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3'd5, rv);               // sampled after third edge
    check("R1 pending after third edge", rv, 32'h1);
    check("R11 irqOut set", {31'h0, irqOut}, 32'h1);
    // R4 writing 0 keeps the bit
    wr(3'd5, 32'h0);
    rd(3'd5, rv);
    check("R4 write zero keeps pending", rv, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, rv);
    check("R4 write one clears", rv, 32'h0);
    check("R11 irqOut cleared", {31'h0, irqOut}, 32'h0);
    // falling edge on rise-only line: nothing
    setPort0(0, 1'b0);
    rd(3'd5, rv);
    check("R2 falling ignored on rise-only line", rv, 32'h0);

    // R2 falling only on line 5, both on line 6
    wr(3'd3, 32'h00060);
    wr(3'd2, 32'h00040);
    setPort0(5, 1'b1);
    rd(3'd5, rv);
    check("R2 rise ignored on fall-only line", rv, 32'h0);
    setPort0(5, 1'b0);
    rd(3'd5, rv);
    check("R2 falling edge sets", rv, 32'h20);
    wr(3'd5, 32'h7FFFF);
    setPort0(6, 1'b1);
    rd(3'd5, rv);
    check("R2 both: rising counts", rv, 32'h40);
    wr(3'd5, 32'h7FFFF);
    setPort0(6, 1'b0);
    rd(3'd5, rv);
    check("R2 both: falling counts", rv, 32'h40);
    wr(3'd5, 32'h7FFFF);

    // R3 masked line
    wr(3'd2, 32'h00100);
    wr(3'd0, 32'h7FEFF);
    setPort0(8, 1'b1);
    rd(3'd5, rv);
    check("R3 masked edge no pending", rv, 32'h0);
    wr(3'd4, 32'h00100);
    rd(3'd5, rv);
    check("R3 masked sw trigger no pending", rv, 32'h0);
    setPort0(8, 1'b0);
    wr(3'd0, 32'h7FFFF);

    // R6 sub-cycle pulse on line 8
    @(negedge clk);
    #0.5 gpioPins[8] = 1'b1;
    #0.5 gpioPins[8] = 1'b0;
    waitCyc(5);
    rd(3'd5, rv);
    check("R6 narrow pulse captured", rv, 32'h100);
    wr(3'd5, 32'h7FFFF);

    // R9 software trigger timing and readback
    @(negedge clk);
    regWrite = 1'b1; regAddr = 3'd4; regWdata = 32'h00400;
    @(negedge clk);
    regWrite = 1'b0;
    regAddr = 3'd5; #1 rv = regRdata;
    check("R9 sw trigger sets at write edge", rv, 32'h400);
    rd(3'd4, rv);
    check("R9 sw trigger reads zero", rv, 32'h0);

    // R5 set beats clear: line 10 pending, new edge lands with the clear
    wr(3'd2, 32'h00400);
    @(negedge clk); gpioPins[10] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regWrite = 1'b1; regAddr = 3'd5; regWdata = 32'h00400;
    @(negedge clk);
    regWrite = 1'b0;
    regAddr = 3'd5; #1 rv = regRdata;
    check("R5 set wins over clear", rv, 32'h400);
    waitCyc(4);
    gpioPins[10] = 1'b0;
    waitCyc(5);
    wr(3'd5, 32'h7FFFF);

    // R7 port select: line 3 from port 2
    wr(3'd2, 32'h00008);
    wr(3'd6, 32'h00002000);
    @(negedge clk); gpioPins[3] = 1'b1; waitCyc(5);
    rd(3'd5, rv);
    check("R7 unselected port ignored", rv, 32'h0);
    @(negedge clk); gpioPins[32+3] = 1'b1; waitCyc(5);
    rd(3'd5, rv);
    check("R7 selected port 2 drives line 3", rv, 32'h8);
    @(negedge clk); gpioPins[32+3] = 1'b0; gpioPins[3] = 1'b0; waitCyc(5);
    wr(3'd5, 32'h7FFFF);
    wr(3'd6, 32'h00007000);
    @(negedge clk); gpioPins[3] = 1'b1; gpioPins[32+3] = 1'b1;
    gpioPins[96+3] = 1'b1; waitCyc(5);
    rd(3'd5, rv);
    check("R7 select 7 is constant low", rv, 32'h0);
    @(negedge clk); gpioPins = '0; waitCyc(5);
    wr(3'd6, 32'h0);
    // line 12 via high select register, port 1
    wr(3'd2, 32'h01000);
    wr(3'd7, 32'h00010000);
    @(negedge clk); gpioPins[16+12] = 1'b1; waitCyc(5);
    rd(3'd5, rv);
    check("R7 high select routes port 1 to line 12", rv, 32'h1000);
    @(negedge clk); gpioPins = '0; waitCyc(5);
    wr(3'd7, 32'h0);
    wr(3'd5, 32'h7FFFF);

    // R8 direct line 17
    wr(3'd2, 32'h20000);
    setPort0(17, 1'b1);
    rd(3'd5, rv);
    check("R8 direct line 17", rv, 32'h20000);
    setPort0(17, 1'b0);
    wr(3'd5, 32'h7FFFF);

    // R10 event path, interrupt disabled on line 4
    wr(3'd0, 32'h7FFEF);
    wr(3'd1, 32'h00010);
    wr(3'd2, 32'h00010);
    @(negedge clk); gpioPins[4] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 no event before edge k+2", {13'h0, evtPulse}, 32'h0);
    @(negedge clk);
    check("R10 event pulse high", {13'h0, evtPulse}, 32'h10);
    @(negedge clk);
    check("R10 event pulse one cycle", {13'h0, evtPulse}, 32'h0);
    rd(3'd5, rv);
    check("R10 event sets no pending", rv, 32'h0);
    setPort0(4, 1'b0);
    wr(3'd1, 32'h0);

    // random phase: R1 R2 R3 R7 R11 against a model
    seedDummy = $urandom(32'd1234);
    gpioPins = '0; directLines = '0;
    waitCyc(5);
    cfgRise = 19'($urandom); cfgFall = 19'($urandom); cfgEn = 19'($urandom);
    wr(3'd0, {13'h0, cfgEn});
    wr(3'd2, {13'h0, cfgRise});
    wr(3'd3, {13'h0, cfgFall});
    wr(3'd5, 32'h7FFFF);
    model = '0;
    for (int it = 0; it < 80; it++) begin
      int line;
      bit oldV, newV;
      line = int'($urandom % 19);
      @(negedge clk);
      oldV = (line < 16) ? gpioPins[line] : directLines[line-16];
      newV = bit'($urandom);
      gpioPins[111:16] = {$urandom, $urandom, $urandom};
      if (line < 16) gpioPins[line] = newV;
      else           directLines[line-16] = newV;
      if (hits(cfgRise[line], cfgFall[line], oldV, newV) && cfgEn[line])
        model[line] = 1'b1;
      waitCyc(5);
      rd(3'd5, rv);
      check("R1/R2/R3 random pending", rv, {13'h0, model});
      check("R11 random irqOut", {31'h0, irqOut}, {31'h0, |(model & cfgEn)});
      if (it % 8 == 7) begin
        wr(3'd5, 32'h7FFFF);
        model = '0;
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule